// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by reading two levels of page table from memory. A requester hands over one address together with the base of the top-level table. The walker reads the top-level entry, and if that entry is valid it reads the entry of the second-level table that the first entry points to. The frame number found there, joined with the page offset of the virtual address, forms the physical address. If either entry is marked invalid, the walk stops and a page fault is reported together with the level at which it happened.

Only one walk is in flight at a time. The memory side is a plain read port that carries one read at a time: the walker presents an address until memory accepts it, then waits for the data, however long that takes. The result stays on the response outputs until the requester acknowledges it, and only then does the walker take the next request. The field widths, the entry size and the position of the valid bit are parameters. The defaults are a 10-bit top index, a 10-bit second index, a 12-bit offset, 4-byte entries and the valid flag in bit 0.

Top module: `ptw_two_level`

## Requirements
- R1: After reset the walker is idle: `req_ready` is 1, `mem_rd_valid` is 0 and `rsp_valid` is 0.
- R2: A request is taken only while `req_ready` is 1, and `req_ready` stays 0 until the result has been acknowledged. The walk uses the `req_vaddr` and `root_base` values present when the request was taken, so later changes to those inputs do not affect it.
- R3: The first read of a walk goes to `root_base + vaddr[31:22] * 4`.
- R4: The second read goes to `entry1[31:12] * 4096 + vaddr[21:12] * 4`, where entry1 is the data returned by the first read.
- R5: If bit 0 of the first entry is 0, the walk ends after one read with `rsp_fault` = 1, `rsp_fault_level` = 0 and `rsp_paddr` = 0.
- R6: If bit 0 of the second entry is 0, the walk ends with `rsp_fault` = 1, `rsp_fault_level` = 1 and `rsp_paddr` = 0.
- R7: When both entries are valid, `rsp_fault` = 0 and `rsp_paddr` = `{entry2[31:12], vaddr[11:0]}`. Bits 11:1 of either entry have no effect.
- R8: `rsp_valid` and all response fields stay stable until a cycle in which `rsp_ack` is 1. After that cycle the walker is idle again.
- R9: A memory read request keeps `mem_rd_valid` high and `mem_rd_addr` unchanged until `mem_rd_ready` is 1. Read data is taken only in a cycle with `mem_rsp_valid` high, whatever the delay.
- R10: A successful walk or a second-level fault makes exactly two reads. A first-level fault makes exactly one. No read is issued while a response is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle; the request is taken on this edge |
| req_vaddr | input | 32 | Virtual address to translate |
| root_base | input | 32 | Byte address of the top-level table |
| mem_rd_valid | output | 1 | Table read request |
| mem_rd_ready | input | 1 | Memory accepts the read |
| mem_rd_addr | output | 32 | Byte address of the entry to read |
| mem_rsp_valid | input | 1 | Read data present |
| mem_rsp_data | input | 32 | Entry read from memory |
| rsp_valid | output | 1 | Result available |
| rsp_ack | input | 1 | Requester takes the result |
| rsp_paddr | output | 32 | Translated physical address, 0 on fault |
| rsp_fault | output | 1 | Page fault |
| rsp_fault_level | output | 1 | Level that faulted: 0 top, 1 second |

## Verification
The bench sweeps all 1024 top-level indices, with second-level indices and offsets that vary along the sweep. Table contents come from an arithmetic rule that mixes valid and invalid entries at both levels and puts junk in the ignored entry bits. A walker that confused the index fields or the entry scaling would send one of its reads to the wrong address. A walker that kept going after a top-level fault would show a second read. A walker that decoded the junk bits would produce the wrong physical address. Memory accept stalls and read latencies vary from walk to walk, and some walks hold the response for several cycles before acknowledging it. A design that sampled the data bus early or dropped its request before it was accepted would return wrong results, and one that let the response drift before the acknowledge would be caught. Some walks change the address and base inputs and keep the request asserted while the walk is running. A walker that failed to capture its inputs, or that accepted a second request, would then translate the wrong address.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

   typedef enum logic [2:0] {
      W_IDLE,
      W_L1_REQ,
      W_L1_WAIT,
      W_L2_REQ,
      W_L2_WAIT,
      W_DONE
   } walk_state_e;

   localparam logic LVL_TOP    = 1'b0;
   localparam logic LVL_SECOND = 1'b1;

endpackage

// File: rtl/ptw_va_split.sv
module ptw_va_split #(
   parameter int unsigned OUTER_W = 10,
   parameter int unsigned INNER_W = 10,
   parameter int unsigned OFF_W   = 12,
   localparam int unsigned VA_W   = OUTER_W + INNER_W + OFF_W
) (
   input  logic [VA_W-1:0]    vaddr,
   output logic [OUTER_W-1:0] outer_idx,
   output logic [INNER_W-1:0] inner_idx,
   output logic [OFF_W-1:0]   page_off
);

   generate
      if (OUTER_W == 0 || INNER_W == 0 || OFF_W == 0) begin : g_bad_split
         $error("ptw_va_split: every address field needs at least one bit");
      end
   endgenerate

   assign outer_idx = vaddr[VA_W-1 -: OUTER_W];
   assign inner_idx = vaddr[OFF_W +: INNER_W];
   assign page_off  = vaddr[OFF_W-1:0];

endmodule

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
   parameter int unsigned ADDR_W      = 32,
   parameter int unsigned IDX_W       = 10,
   parameter int unsigned ENTRY_BYTES = 4
) (
   input  logic [ADDR_W-1:0] table_base,
   input  logic [IDX_W-1:0]  index,
   output logic [ADDR_W-1:0] entry_addr
);

   localparam int unsigned SCALE_SH = $clog2(ENTRY_BYTES);

   generate
      if ((1 << SCALE_SH) != ENTRY_BYTES) begin : g_bad_size
         $error("ptw_addr_gen: entry size must be a power of two");
      end
      if (IDX_W + SCALE_SH > ADDR_W) begin : g_bad_width
         $error("ptw_addr_gen: scaled index wider than the address");
      end
      if (SCALE_SH == 0) begin : g_byte_entries
         assign entry_addr = table_base + ADDR_W'(index);
      end else begin : g_scaled_entries
         assign entry_addr = table_base + (ADDR_W'(index) << SCALE_SH);
      end
   endgenerate

endmodule

// File: rtl/ptw_pte_decode.sv
module ptw_pte_decode #(
   parameter int unsigned PTE_W     = 32,
   parameter int unsigned OFF_W     = 12,
   parameter int unsigned VALID_POS = 0,
   localparam int unsigned FRAME_W  = PTE_W - OFF_W
) (
   input  logic [PTE_W-1:0]   pte,
   output logic               pte_valid,
   output logic [FRAME_W-1:0] pte_frame
);

   logic unused_low_bits;

   generate
      if (VALID_POS >= OFF_W) begin : g_bad_valid_pos
         $error("ptw_pte_decode: valid flag must sit below the frame field");
      end
   endgenerate

   assign pte_valid       = pte[VALID_POS];
   assign pte_frame       = pte[PTE_W-1:OFF_W];
   assign unused_low_bits = ^pte[OFF_W-1:0];

endmodule

// File: rtl/ptw_walk_ctrl.sv
module ptw_walk_ctrl
   import ptw_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic req_valid,
   input  logic mem_rd_ready,
   input  logic mem_rsp_valid,
   input  logic entry_valid,
   input  logic rsp_ack,
   output logic req_ready,
   output logic mem_rd_valid,
   output logic rd_second,
   output logic rsp_valid,
   output logic take_req,
   output logic take_outer,
   output logic finish,
   output logic finish_fault,
   output logic finish_level
);

   walk_state_e state_q, state_d;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         W_IDLE:    if (req_valid)     state_d = W_L1_REQ;
         W_L1_REQ:  if (mem_rd_ready)  state_d = W_L1_WAIT;
         W_L1_WAIT: if (mem_rsp_valid) state_d = entry_valid ? W_L2_REQ : W_DONE;
         W_L2_REQ:  if (mem_rd_ready)  state_d = W_L2_WAIT;
         W_L2_WAIT: if (mem_rsp_valid) state_d = W_DONE;
         W_DONE:    if (rsp_ack)       state_d = W_IDLE;
         default:                      state_d = W_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) state_q <= W_IDLE;
      else        state_q <= state_d;
   end

   assign req_ready    = (state_q == W_IDLE);
   assign mem_rd_valid = (state_q == W_L1_REQ) || (state_q == W_L2_REQ);
   assign rd_second    = (state_q == W_L2_REQ);
   assign rsp_valid    = (state_q == W_DONE);
   assign take_req     = req_ready && req_valid;
   assign take_outer   = (state_q == W_L1_WAIT) && mem_rsp_valid && entry_valid;
   assign finish       = mem_rsp_valid &&
                         (((state_q == W_L1_WAIT) && !entry_valid) || (state_q == W_L2_WAIT));
   assign finish_fault = !entry_valid;
   assign finish_level = (state_q == W_L2_WAIT) ? LVL_SECOND : LVL_TOP;

   assert_one_walk_R2: assert property (@(posedge clk) disable iff (!rst_n)
      take_req |=> !req_ready);

   assert_top_fault_single_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (finish && finish_fault && (finish_level == LVL_TOP)) |=> !mem_rd_valid && rsp_valid);

   assert_no_read_during_rsp_R10: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> !mem_rd_valid);

   assert_idle_after_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_ack) |=> req_ready && !rsp_valid);

endmodule

// File: rtl/ptw_two_level.sv
module ptw_two_level
   import ptw_pkg::*;
#(
   parameter int unsigned OUTER_W     = 10,
   parameter int unsigned INNER_W     = 10,
   parameter int unsigned OFF_W       = 12,
   parameter int unsigned PTE_W       = 32,
   parameter int unsigned ENTRY_BYTES = 4,
   parameter int unsigned VALID_POS   = 0,
   localparam int unsigned VA_W       = OUTER_W + INNER_W + OFF_W,
   localparam int unsigned FRAME_W    = PTE_W - OFF_W,
   localparam int unsigned PA_W       = FRAME_W + OFF_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [VA_W-1:0]   req_vaddr,
   input  logic [PA_W-1:0]   root_base,
   output logic              mem_rd_valid,
   input  logic              mem_rd_ready,
   output logic [PA_W-1:0]   mem_rd_addr,
   input  logic              mem_rsp_valid,
   input  logic [PTE_W-1:0]  mem_rsp_data,
   output logic              rsp_valid,
   input  logic              rsp_ack,
   output logic [PA_W-1:0]   rsp_paddr,
   output logic              rsp_fault,
   output logic              rsp_fault_level
);

   generate
      if (ENTRY_BYTES * 8 < PTE_W) begin : g_bad_entry
         $error("ptw_two_level: entry bytes too few for the entry width");
      end
      if (((1 << INNER_W) * ENTRY_BYTES) > (1 << OFF_W)) begin : g_bad_inner
         $error("ptw_two_level: second-level table does not fit one page");
      end
   endgenerate

   logic [VA_W-1:0]    va_q;
   logic [PA_W-1:0]    base_q;
   logic [FRAME_W-1:0] frame_q;
   logic [PA_W-1:0]    paddr_q;
   logic               fault_q;
   logic               level_q;

   logic [OUTER_W-1:0] outer_idx;
   logic [INNER_W-1:0] inner_idx;
   logic [OFF_W-1:0]   page_off;
   logic [PA_W-1:0]    outer_addr;
   logic [PA_W-1:0]    inner_addr;
   logic               entry_valid;
   logic [FRAME_W-1:0] entry_frame;

   logic take_req, take_outer, finish, finish_fault, finish_level, rd_second;

   ptw_va_split #(.OUTER_W(OUTER_W), .INNER_W(INNER_W), .OFF_W(OFF_W)) u_split (
      .vaddr     (va_q),
      .outer_idx (outer_idx),
      .inner_idx (inner_idx),
      .page_off  (page_off)
   );

   ptw_addr_gen #(.ADDR_W(PA_W), .IDX_W(OUTER_W), .ENTRY_BYTES(ENTRY_BYTES)) u_top_addr (
      .table_base (base_q),
      .index      (outer_idx),
      .entry_addr (outer_addr)
   );

   ptw_addr_gen #(.ADDR_W(PA_W), .IDX_W(INNER_W), .ENTRY_BYTES(ENTRY_BYTES)) u_second_addr (
      .table_base ({frame_q, {OFF_W{1'b0}}}),
      .index      (inner_idx),
      .entry_addr (inner_addr)
   );

   ptw_pte_decode #(.PTE_W(PTE_W), .OFF_W(OFF_W), .VALID_POS(VALID_POS)) u_decode (
      .pte       (mem_rsp_data),
      .pte_valid (entry_valid),
      .pte_frame (entry_frame)
   );

   ptw_walk_ctrl u_ctrl (
      .clk           (clk),
      .rst_n         (rst_n),
      .req_valid     (req_valid),
      .mem_rd_ready  (mem_rd_ready),
      .mem_rsp_valid (mem_rsp_valid),
      .entry_valid   (entry_valid),
      .rsp_ack       (rsp_ack),
      .req_ready     (req_ready),
      .mem_rd_valid  (mem_rd_valid),
      .rd_second     (rd_second),
      .rsp_valid     (rsp_valid),
      .take_req      (take_req),
      .take_outer    (take_outer),
      .finish        (finish),
      .finish_fault  (finish_fault),
      .finish_level  (finish_level)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         va_q    <= '0;
         base_q  <= '0;
         frame_q <= '0;
         paddr_q <= '0;
         fault_q <= 1'b0;
         level_q <= LVL_TOP;
      end else begin
         if (take_req) begin
            va_q   <= req_vaddr;
            base_q <= root_base;
         end
         if (take_outer) frame_q <= entry_frame;
         if (finish) begin
            fault_q <= finish_fault;
            level_q <= finish_level;
            paddr_q <= finish_fault ? '0 : {entry_frame, page_off};
         end
      end
   end

   assign mem_rd_addr     = rd_second ? inner_addr : outer_addr;
   assign rsp_paddr       = paddr_q;
   assign rsp_fault       = fault_q;
   assign rsp_fault_level = level_q;

   assert_rd_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd_valid && !mem_rd_ready) |=> mem_rd_valid && $stable(mem_rd_addr));

   assert_rsp_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_ack) |=> rsp_valid && $stable(rsp_paddr) &&
                                  $stable(rsp_fault) && $stable(rsp_fault_level));

   assert_fault_clears_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_fault) |-> (rsp_paddr == '0));

   assert_inputs_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd_valid && !rsp_valid) |=> $stable(va_q) && $stable(base_q));

endmodule

// File: tb/tb_ptw_two_level.sv
`timescale 1ns/1ps
module tb_ptw_two_level;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        req_valid, req_ready;
   logic [31:0] req_vaddr, root_base;
   logic        mem_rd_valid, mem_rd_ready;
   logic [31:0] mem_rd_addr;
   logic        mem_rsp_valid;
   logic [31:0] mem_rsp_data;
   logic        rsp_valid, rsp_ack;
   logic [31:0] rsp_paddr;
   logic        rsp_fault, rsp_fault_level;

   int tests = 0;
   int fails = 0;
   bit done  = 1'b0;

   int          stall_cfg = 0;
   int          lat_cfg   = 0;
   logic [31:0] cur_base  = 32'h0;
   logic [31:0] rd_log [4];
   int          rd_cnt    = 0;
   int          hold_errs = 0;

   always #4 clk = ~clk;

   ptw_two_level dut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready),
      .req_vaddr(req_vaddr), .root_base(root_base),
      .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready), .mem_rd_addr(mem_rd_addr),
      .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
      .rsp_valid(rsp_valid), .rsp_ack(rsp_ack),
      .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault), .rsp_fault_level(rsp_fault_level)
   );

   function automatic logic [31:0] top_entry(input logic [9:0] idx);
      logic [19:0] fr = 20'h100 + 20'(idx);
      top_entry = {fr, 11'h550, (idx % 5 != 3) ? 1'b1 : 1'b0};
   endfunction

   function automatic logic [31:0] second_entry(input logic [19:0] fr, input logic [9:0] j);
      logic [19:0] nf = 20'((32'(fr) * 37 + 32'(j)) & 32'hFFFFF);
      second_entry = {nf, 11'h2D3, (j % 7 != 4) ? 1'b1 : 1'b0};
   endfunction

   function automatic logic [31:0] mem_model(input logic [31:0] a);
      if (a >= cur_base && a < cur_base + 32'd4096)
         mem_model = top_entry(10'((a - cur_base) >> 2));
      else
         mem_model = second_entry(a[31:12], a[11:2]);
   endfunction

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // memory responder: stalls accept, then answers after a latency (R9)
   initial begin
      logic [31:0] a;
      mem_rd_ready  = 1'b0;
      mem_rsp_valid = 1'b0;
      mem_rsp_data  = '0;
      forever begin
         @(negedge clk);
         mem_rsp_valid = 1'b0;
         if (rst_n === 1'b1 && mem_rd_valid === 1'b1) begin
            a = mem_rd_addr;
            for (int k = 0; k < stall_cfg; k++) begin
               @(negedge clk);
               if (mem_rd_valid !== 1'b1 || mem_rd_addr !== a) hold_errs++;
            end
            mem_rd_ready = 1'b1;
            @(negedge clk);
            mem_rd_ready = 1'b0;
            if (rd_cnt < 4) rd_log[rd_cnt] = a;
            rd_cnt++;
            for (int k = 0; k < lat_cfg; k++) begin
               mem_rsp_data = 32'hDEAD_0001;
               @(negedge clk);
            end
            mem_rsp_valid = 1'b1;
            mem_rsp_data  = mem_model(a);
         end
      end
   end

   task automatic do_walk(input logic [31:0] va, input logic [31:0] base,
                          input int hold, input bit poke);
      logic [9:0]  oi = va[31:22];
      logic [9:0]  ij = va[21:12];
      logic [31:0] e1 = top_entry(oi);
      logic [31:0] e2 = second_entry(e1[31:12], ij);
      logic        x_fault = !e1[0] || !e2[0];
      logic        x_level = e1[0];
      logic [31:0] x_pa    = x_fault ? 32'h0 : {e2[31:12], va[11:0]};
      int          x_reads = e1[0] ? 2 : 1;
      int          waited  = 0;
      bit          busy_ok = 1'b1;
      logic [31:0] held_pa;
      bit          stable_ok = 1'b1;

      rd_cnt    = 0;
      hold_errs = 0;
      cur_base  = base;
      @(negedge clk);
      req_vaddr = va;
      root_base = base;
      req_valid = 1'b1;
      @(negedge clk);
      if (poke) begin
         req_vaddr = ~va;
         root_base = base + 32'h0010_0000;
      end else begin
         req_valid = 1'b0;
      end
      while (rsp_valid !== 1'b1 && waited < 300) begin
         if (req_ready !== 1'b0) busy_ok = 1'b0;
         @(negedge clk);
         waited++;
      end
      req_valid = 1'b0;
      chk(busy_ok, "R2 busy walker refuses requests", {31'b0, req_ready}, 32'h0);
      chk(rsp_valid === 1'b1, "R9 response arrives", {31'b0, rsp_valid}, 32'h1);
      held_pa = rsp_paddr;
      for (int h = 0; h < hold; h++) begin
         @(negedge clk);
         if (rsp_valid !== 1'b1 || rsp_paddr !== held_pa) stable_ok = 1'b0;
      end
      if (hold > 0) chk(stable_ok, "R8 response held until ack", rsp_paddr, held_pa);
      chk(rsp_fault === x_fault, x_fault ? (x_level ? "R6 fault flag" : "R5 fault flag") : "R7 fault flag",
          {31'b0, rsp_fault}, {31'b0, x_fault});
      if (x_fault)
         chk(rsp_fault_level === x_level, x_level ? "R6 fault level" : "R5 fault level",
             {31'b0, rsp_fault_level}, {31'b0, x_level});
      chk(rsp_paddr === x_pa, "R7 physical address", rsp_paddr, x_pa);
      chk(rd_cnt == x_reads, "R10 read count", 32'(rd_cnt), 32'(x_reads));
      chk(rd_log[0] === base + {20'b0, oi, 2'b00}, "R3 first read address",
          rd_log[0], base + {20'b0, oi, 2'b00});
      if (e1[0])
         chk(rd_log[1] === {e1[31:12], 12'h0} + {20'b0, ij, 2'b00}, "R4 second read address",
             rd_log[1], {e1[31:12], 12'h0} + {20'b0, ij, 2'b00});
      chk(hold_errs == 0, "R9 read request held while stalled", 32'(hold_errs), 32'h0);
      rsp_ack = 1'b1;
      @(negedge clk);
      rsp_ack = 1'b0;
      chk(rsp_valid === 1'b0 && req_ready === 1'b1, "R8 idle after ack",
          {30'b0, rsp_valid, req_ready}, 32'h1);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      rst_n     = 1'b0;
      req_valid = 1'b0;
      req_vaddr = '0;
      root_base = '0;
      rsp_ack   = 1'b0;
      repeat (3) @(negedge clk);
      chk(req_ready === 1'b1 && mem_rd_valid === 1'b0 && rsp_valid === 1'b0,
          "R1 reset state", {29'b0, req_ready, mem_rd_valid, rsp_valid}, 32'h4);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready === 1'b1 && mem_rd_valid === 1'b0 && rsp_valid === 1'b0,
          "R1 idle after reset", {29'b0, req_ready, mem_rd_valid, rsp_valid}, 32'h4);

      // corner cases: all-ones address (top fault), top-valid with max indices, zero address
      do_walk(32'hFFFF_FFFF, 32'h0008_0000, 2, 1'b0);
      do_walk({10'd1022, 10'd1023, 12'hFFF}, 32'h0008_0000, 0, 1'b1);
      do_walk(32'h0000_0000, 32'h0009_0040, 1, 1'b0);
      do_walk({10'd2, 10'd4, 12'h123}, 32'h0008_0000, 3, 1'b1);

      // sweep over every top-level index
      for (int i = 0; i < 1024; i++) begin
         stall_cfg = i % 3;
         lat_cfg   = (i / 3) % 3;
         do_walk({10'(i), 10'((i * 13 + 5) % 1024), 12'((i * 291) % 4096)},
                 (i % 2 == 0) ? 32'h0008_0000 : 32'h0009_0040,
                 i % 4, (i % 8) == 7);
      end

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule